// File: doc/BRIEF.md
# Guarded I2C EEPROM Slave Controller

This block is the serial front end of a 1024-byte nonvolatile store reached over a two-wire I2C bus. The store is split into 8 blocks of 128 bytes. Each block holds 8 pages of 16 bytes. The block samples SCL and SDA through a synchronizer and finds START and STOP conditions. It decodes the device byte and the word-address byte. Write data goes into a 16-byte page buffer. Reads are served from a behavioral register array, which stands in for the real cells.

A master writes by sending the device byte, the word address and one to sixteen data bytes. A STOP then starts a self-timed program cycle. While that cycle runs, `busy_o` is high and the device address is refused. A master reads either at the current pointer or after setting the pointer with an address-only write followed by a repeated START. An external permission checker watches `chk_addr_o` and reports whether reads and writes are allowed at that location. A write-protect input and an active-low hold input give board-level control.

Top module: `guarded_i2c_eeprom`

## Requirements
- R1: A device byte whose top five bits are 10101 (device codes A8h to AFh) is acknowledged when the block is not busy. Any other device byte is not acknowledged, and the block ignores the bus until the next START.
- R2: In a write, device-byte bits [2:1] form word-address bits [9:8] and the next byte forms bits [7:0]. A data byte written there reads back after the program cycle.
- R3: During a page write only address bits [3:0] advance, so byte 15 of a page is followed by byte 0 of the same page.
- R4: When a 17th data byte arrives before STOP, it is not acknowledged, and nothing from that transaction is programmed.
- R5: During a read only address bits [6:0] advance after each byte. Bits [9:7] never change, so the address after offset 127 of a block is offset 0 of the same block.
- R6: On a read, device-byte bits [2:1] are ignored. The block latched by the last write command is used.
- R7: A STOP that ends a write with at least one accepted data byte raises `busy_o` for WR_TICKS clock cycles. During that time the device byte is not acknowledged. The buffered bytes are programmed when the cycle ends.
- R8: With `wp_i` high, data bytes are not acknowledged and nothing is programmed. The device byte and the word address are still acknowledged, so the word address still sets the pointer.
- R9: While `hold_ni` is low, the serial state machine is held in its idle state and SDA is released. After release, a new START is served normally.
- R10: A read device byte is not acknowledged when `chk_rd_ok_i` is low for the pointer. A data byte is not acknowledged, and the transaction programs nothing, when `chk_wr_ok_i` is low for the pointer.
- R11: After reset every byte reads FFh. Read data is shifted out MSB first. After a master NACK, SDA is released and no further byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_ni | input | 1 | Active-low hold; keeps the serial engine idle while low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| wp_i | input | 1 | Write protect, active high |
| chk_addr_o | output | 10 | Current word pointer shown to the permission checker |
| chk_rd_ok_i | input | 1 | Checker allows reads at `chk_addr_o` |
| chk_wr_ok_i | input | 1 | Checker allows writes at `chk_addr_o` |
| busy_o | output | 1 | Program cycle in progress |

## Verification
The bench starts page writes near the end of a page and reads across the end of a 128-byte block. A design that carried the increment into the page or block bits would return bytes from the neighbouring page or block. It sends a 17th data byte and checks that the first sixteen bytes were not programmed, which catches a design that commits a partial transaction. It reads with block bits in the device byte that differ from the latched block. It also checks that the pointer survives write-protected and permission-denied writes. Finally it pulses the hold input while the slave is driving a data bit, to show that the slave releases SDA.

// File: rtl/gie_pkg.sv
package gie_pkg;
  localparam logic [4:0] DEV_ID = 5'b10101;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/gie_line_sampler.sv
module gie_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_q[SYNC_STAGES-1];
      sda_d <= sda_q[SYNC_STAGES-1];
    end
  end

  logic scl_s, sda_s;
  assign scl_s      = scl_q[SYNC_STAGES-1];
  assign sda_s      = sda_q[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SDA edges while SCL stays high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/gie_wr_timer.sv
module gie_wr_timer #(
  parameter int TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int TW = $clog2(TICKS + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i && !busy_o) cnt_q <= TW'(TICKS);
    else if (busy_o)             cnt_q <= cnt_q - TW'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == TW'(1));

  p_busy_persists_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/gie_page_store.sv
module gie_page_store #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lat_clr_i,
  input  logic                     lat_we_i,
  input  logic [PAGE_W-1:0]        lat_idx_i,
  input  logic [7:0]               lat_data_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] commit_page_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_BYTES = 1 << PAGE_W;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] lat_q [PG_BYTES];
  logic [PG_BYTES-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < PG_BYTES; i++) lat_q[i] <= 8'hFF;
    end else if (lat_clr_i) begin
      vld_q <= '0;
    end else if (lat_we_i) begin
      lat_q[lat_idx_i]   <= lat_data_i;
      vld_q[lat_idx_i]   <= 1'b1;
    end else if (commit_i) begin
      vld_q <= '0;
    end
  end

  // erased cells read as all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int i = 0; i < PG_BYTES; i++)
        if (vld_q[i]) mem_q[{commit_page_i, PAGE_W'(i)}] <= lat_q[i];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/gie_ctrl.sv
module gie_ctrl
  import gie_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4,
  parameter int BLK_W  = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     hold_ni,
  input  logic                     scl_rise_i,
  input  logic                     scl_fall_i,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     sda_i,
  input  logic                     wp_i,
  input  logic                     rd_ok_i,
  input  logic                     wr_ok_i,
  input  logic                     busy_i,
  input  logic [7:0]               rd_data_i,
  output logic                     sda_pull_o,
  output logic [ADDR_W-1:0]        ptr_o,
  output logic                     lat_clr_o,
  output logic                     lat_we_o,
  output logic [PAGE_W-1:0]        lat_idx_o,
  output logic [7:0]               lat_data_o,
  output logic                     wr_go_o,
  output logic [ADDR_W-PAGE_W-1:0] commit_page_o
);
  localparam int HI_W     = ADDR_W - 8;
  localparam int PG_BYTES = 1 << PAGE_W;
  localparam int CW       = PAGE_W + 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(PG_BYTES);

  bus_state_e       st_q;
  logic [3:0]       bcnt_q;
  logic [7:0]       sh_q, tx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [HI_W-1:0]  hi_q;
  logic             rw_q, mack_q, cancel_q, txn_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; bcnt_q <= '0; sh_q <= '0; tx_q <= '0;
      ptr_q <= '0; hi_q <= '0; rw_q <= 1'b0; mack_q <= 1'b0;
      cancel_q <= 1'b0; txn_q <= 1'b0; cnt_q <= '0;
      sda_pull_o <= 1'b0; lat_clr_o <= 1'b0; lat_we_o <= 1'b0;
      lat_idx_o <= '0; lat_data_o <= '0; wr_go_o <= 1'b0; commit_page_o <= '0;
    end else begin
      lat_clr_o <= 1'b0;
      lat_we_o  <= 1'b0;
      wr_go_o   <= 1'b0;
      if (!hold_ni) begin
        st_q <= ST_IDLE; bcnt_q <= '0; sda_pull_o <= 1'b0;
        txn_q <= 1'b0; cancel_q <= 1'b0; cnt_q <= '0;
      end else if (start_i) begin
        st_q <= ST_DEV; bcnt_q <= '0; sda_pull_o <= 1'b0;
        txn_q <= 1'b0;
      end else if (stop_i) begin
        if (txn_q && !cancel_q && cnt_q != '0) begin
          wr_go_o       <= 1'b1;
          commit_page_o <= ptr_q[ADDR_W-1:PAGE_W];
        end
        st_q <= ST_IDLE; sda_pull_o <= 1'b0; txn_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_DEV, ST_ADDR, ST_WDATA: begin
            if (scl_rise_i) begin
              sh_q   <= {sh_q[6:0], sda_i};
              bcnt_q <= bcnt_q + 4'd1;
            end
            if (scl_fall_i && bcnt_q == 4'd8) begin
              bcnt_q <= '0;
              if (st_q == ST_DEV) begin
                if (sh_q[7:3] == DEV_ID && !busy_i && (!sh_q[0] || rd_ok_i)) begin
                  sda_pull_o <= 1'b1;
                  st_q       <= ST_DEV_ACK;
                  rw_q       <= sh_q[0];
                  if (!sh_q[0]) hi_q <= sh_q[HI_W:1];
                end else st_q <= ST_SKIP;
              end else if (st_q == ST_ADDR) begin
                ptr_q      <= {hi_q, sh_q};
                sda_pull_o <= 1'b1;
                st_q       <= ST_ADDR_ACK;
                lat_clr_o  <= 1'b1;
                cnt_q      <= '0;
                cancel_q   <= 1'b0;
                txn_q      <= 1'b1;
              end else if (cnt_q == CNT_MAX || wp_i || !wr_ok_i) begin
                cancel_q <= 1'b1;
                st_q     <= ST_SKIP;
              end else begin
                lat_we_o   <= 1'b1;
                lat_idx_o  <= ptr_q[PAGE_W-1:0];
                lat_data_o <= sh_q;
                ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
                cnt_q      <= cnt_q + CW'(1);
                sda_pull_o <= 1'b1;
                st_q       <= ST_WDATA_ACK;
              end
            end
          end
          ST_DEV_ACK: if (scl_fall_i) begin
            bcnt_q <= '0;
            if (rw_q) begin
              tx_q       <= rd_data_i;
              sda_pull_o <= ~rd_data_i[7];
              st_q       <= ST_RDATA;
            end else begin
              sda_pull_o <= 1'b0;
              st_q       <= ST_ADDR;
            end
          end
          ST_ADDR_ACK, ST_WDATA_ACK: if (scl_fall_i) begin
            sda_pull_o <= 1'b0;
            bcnt_q     <= '0;
            st_q       <= ST_WDATA;
          end
          ST_RDATA: if (scl_fall_i) begin
            if (bcnt_q == 4'd7) begin
              sda_pull_o <= 1'b0;
              bcnt_q     <= '0;
              st_q       <= ST_RACK;
              ptr_q[BLK_W-1:0] <= ptr_q[BLK_W-1:0] + BLK_W'(1);
            end else begin
              tx_q       <= {tx_q[6:0], 1'b0};
              sda_pull_o <= ~tx_q[6];
              bcnt_q     <= bcnt_q + 4'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise_i) mack_q <= ~sda_i;
            if (scl_fall_i) begin
              if (mack_q) begin
                tx_q       <= rd_data_i;
                sda_pull_o <= ~rd_data_i[7];
                st_q       <= ST_RDATA;
              end else st_q <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o = ptr_q;

  p_blk_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_RDATA, ST_RACK}) && ($past(st_q) inside {ST_RDATA, ST_RACK})
    |-> ptr_q[ADDR_W-1:BLK_W] == $past(ptr_q[ADDR_W-1:BLK_W]));
  p_page_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_WDATA, ST_WDATA_ACK}) && ($past(st_q) inside {ST_WDATA, ST_WDATA_ACK})
    |-> ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]));
  p_cnt_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  p_busy_no_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> st_q != ST_DEV_ACK);
  p_hold_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ni |=> !sda_pull_o && st_q == ST_IDLE);
endmodule

// File: rtl/guarded_i2c_eeprom.sv
module guarded_i2c_eeprom #(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 4,
  parameter int BLK_W    = 7,
  parameter int WR_TICKS = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              wp_i,
  output logic [ADDR_W-1:0] chk_addr_o,
  input  logic              chk_rd_ok_i,
  input  logic              chk_wr_ok_i,
  output logic              busy_o
);
  logic scl_rise, scl_fall, start, stop, sda_s;
  logic lat_clr, lat_we, wr_go, wr_done;
  logic [PAGE_W-1:0] lat_idx;
  logic [7:0] lat_data, rd_data;
  logic [ADDR_W-PAGE_W-1:0] commit_page;

  gie_line_sampler #(.SYNC_STAGES(2)) u_sampler (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop), .sda_o(sda_s)
  );

  gie_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W)) u_ctrl (
    .clk_i, .rst_ni, .hold_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .sda_i(sda_s),
    .wp_i, .rd_ok_i(chk_rd_ok_i), .wr_ok_i(chk_wr_ok_i),
    .busy_i(busy_o), .rd_data_i(rd_data),
    .sda_pull_o, .ptr_o(chk_addr_o),
    .lat_clr_o(lat_clr), .lat_we_o(lat_we), .lat_idx_o(lat_idx),
    .lat_data_o(lat_data), .wr_go_o(wr_go), .commit_page_o(commit_page)
  );

  gie_wr_timer #(.TICKS(WR_TICKS)) u_timer (
    .clk_i, .rst_ni, .start_i(wr_go), .busy_o, .done_o(wr_done)
  );

  gie_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk_i, .rst_ni,
    .lat_clr_i(lat_clr), .lat_we_i(lat_we), .lat_idx_i(lat_idx),
    .lat_data_i(lat_data), .commit_i(wr_done), .commit_page_i(commit_page),
    .rd_addr_i(chk_addr_o), .rd_data_o(rd_data)
  );
endmodule

// File: tb/guarded_i2c_eeprom_bench.sv
module guarded_i2c_eeprom_bench;
  localparam int Q = 8;
  localparam int TICKS = 300;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hold_ni = 1'b1;
  logic scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic sda_pull, busy;
  logic [9:0] chk_addr;
  logic [7:0] rd_deny = '0, wr_deny = '0;
  wire sda_line = m_sda & ~sda_pull;

  always #4 clk_i = ~clk_i;

  guarded_i2c_eeprom #(.WR_TICKS(TICKS)) u_guarded_i2c_eeprom (
    .clk_i, .rst_ni, .hold_ni, .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .wp_i(wp), .chk_addr_o(chk_addr),
    .chk_rd_ok_i(!rd_deny[chk_addr[9:7]]), .chk_wr_ok_i(!wr_deny[chk_addr[9:7]]),
    .busy_o(busy)
  );

  int total = 0, bad = 0;
  logic [7:0] model [1024];

  function automatic logic [7:0] dev_wr(input logic [9:0] a);
    return {5'b10101, a[9:8], 1'b0};
  endfunction
  function automatic logic [9:0] page_step(input logic [9:0] a, input int i);
    return {a[9:4], a[3:0] + 4'(i)};
  endfunction
  function automatic logic [9:0] blk_step(input logic [9:0] a, input int i);
    return {a[9:7], a[6:0] + 7'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk_i); endtask
  task automatic i2c_start;
    m_sda = 1; wq; scl = 1; wq; m_sda = 0; wq; scl = 0; wq;
  endtask
  task automatic i2c_stop;
    m_sda = 0; wq; scl = 1; wq; m_sda = 1; wq; wq;
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq; scl = 1; wq; wq; scl = 0; wq;
    end
    m_sda = 1; wq; scl = 1; wq; ack = !sda_line; wq; scl = 0; wq;
  endtask
  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 0; i < 8; i++) begin
      wq; scl = 1; wq; b = {b[6:0], sda_line}; wq; scl = 0;
      if (i != 7) wq;
    end
    wq; m_sda = !mack; wq; scl = 1; wq; wq; scl = 0; wq; m_sda = 1;
  endtask
  task automatic wait_idle;
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk_i); n++; end
  endtask

  // address-only write, repeated START, read n bytes with given B2B1 bits
  task automatic read_check(input logic [9:0] a, input int n, input logic [1:0] junk,
                            input string req);
    bit ack; logic [7:0] d;
    i2c_start; send_byte(dev_wr(a), ack); send_byte(a[7:0], ack);
    i2c_start; send_byte({5'b10101, junk, 1'b1}, ack);
    chk(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == model[blk_step(a, i)], req, d, model[blk_step(a, i)]);
    end
    i2c_stop;
  endtask

  task automatic write_bytes(input logic [9:0] a, input int n, input logic [7:0] base,
                             output int acks);
    bit ack;
    acks = 0;
    i2c_start; send_byte(dev_wr(a), ack); send_byte(a[7:0], ack);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), ack);
      if (ack) acks++;
    end
    i2c_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack; int acks; logic [7:0] d; logic [9:0] ra [6]; logic [7:0] rv [6];
    void'($urandom(32'd41));
    for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk_i);
    rst_ni = 1;
    repeat (5) @(negedge clk_i);
    chk(!busy && !sda_pull, "R11 reset", {busy, sda_pull}, 0);

    // R11 erased content, R1 decode
    read_check(10'h000, 2, 2'b00, "R11 erased");
    i2c_start; send_byte(8'hA0, ack); i2c_stop;
    chk(!ack, "R1 wrong id", ack, 0);
    i2c_start; send_byte(8'hB8, ack); i2c_stop;
    chk(!ack, "R1 wrong id B8", ack, 0);

    // R2 byte write, R7 busy behaviour
    write_bytes(10'h123, 1, 8'h5C, acks);
    chk(acks == 1, "R2 data ack", acks, 1);
    chk(busy, "R7 busy after stop", busy, 1);
    i2c_start; send_byte(8'hA8, ack); i2c_stop;
    chk(!ack, "R7 nack while busy", ack, 0);
    wait_idle;
    chk(!busy, "R7 busy ends", busy, 0);
    model[10'h123] = 8'h5C;
    read_check(10'h123, 1, 2'b01, "R2 readback");

    // R3 page wrap
    write_bytes(10'h24E, 4, 8'hA0, acks);
    chk(acks == 4, "R3 acks", acks, 4);
    wait_idle;
    for (int i = 0; i < 4; i++) model[page_step(10'h24E, i)] = 8'hA0 + 8'(i);
    read_check(10'h240, 16, 2'b10, "R3 page wrap");

    // R4 overflow cancels transaction
    write_bytes(10'h300, 17, 8'h11, acks);
    chk(acks == 16, "R4 17th nack", acks, 16);
    chk(!busy, "R4 no cycle", busy, 0);
    read_check(10'h300, 2, 2'b11, "R4 nothing programmed");

    // R5 block wrap, R6 block bits ignored on read
    write_bytes(10'h17E, 2, 8'h70, acks); wait_idle;
    write_bytes(10'h100, 4, 8'h30, acks); wait_idle;
    for (int i = 0; i < 2; i++) model[page_step(10'h17E, i)] = 8'h70 + 8'(i);
    for (int i = 0; i < 4; i++) model[page_step(10'h100, i)] = 8'h30 + 8'(i);
    read_check(10'h17E, 4, 2'b11, "R5 block wrap");
    i2c_start; send_byte(8'hAF, ack); recv_byte(0, d); i2c_stop;
    chk(ack && d == model[10'h102], "R6 current read latched block", d, model[10'h102]);

    // R8 write protect: address accepted, data refused, pointer set
    wp = 1;
    i2c_start; send_byte(dev_wr(10'h050), ack);
    chk(ack, "R8 dev ack", ack, 1);
    send_byte(8'h50, ack);
    chk(ack, "R8 addr ack", ack, 1);
    send_byte(8'h00, ack);
    chk(!ack, "R8 data nack", ack, 0);
    i2c_stop;
    chk(!busy, "R8 no cycle", busy, 0);
    wp = 0;
    i2c_start; send_byte(8'hA9, ack); recv_byte(0, d);
    chk(!sda_pull, "R11 release after nack", sda_pull, 0);
    i2c_stop;
    chk(d == 8'hFF, "R8 pointer set, not written", d, 8'hFF);

    // R10 permission checker
    wr_deny[5] = 1;
    write_bytes(10'h2A0, 1, 8'h00, acks);
    chk(acks == 0 && !busy, "R10 write denied", acks, 0);
    wr_deny[5] = 0;
    read_check(10'h2A0, 1, 2'b00, "R10 nothing written");
    rd_deny[6] = 1;
    i2c_start; send_byte(dev_wr(10'h310), ack); send_byte(8'h10, ack);
    i2c_start; send_byte(8'hA9, ack); i2c_stop;
    chk(!ack, "R10 read denied", ack, 0);
    rd_deny[6] = 0;

    // R9 hold while slave drives a data bit (0x5C: MSB 0)
    i2c_start; send_byte(dev_wr(10'h123), ack); send_byte(8'h23, ack);
    i2c_start; send_byte(8'hA9, ack);
    chk(sda_pull, "R11 MSB driven first", sda_pull, 1);
    hold_ni = 0; repeat (3) @(negedge clk_i);
    chk(!sda_pull, "R9 hold releases sda", sda_pull, 0);
    hold_ni = 1; repeat (2) @(negedge clk_i);
    i2c_stop;
    i2c_start; send_byte(8'hA8, ack); i2c_stop;
    chk(ack, "R9 serves after hold", ack, 1);

    // random byte writes then readback
    for (int k = 0; k < 6; k++) begin
      ra[k] = 10'($urandom);
      if (ra[k][9:7] == 3'd5 || ra[k][9:7] == 3'd6) ra[k][9] = 1'b0;
      rv[k] = 8'($urandom);
      write_bytes(ra[k], 1, rv[k], acks);
      chk(acks == 1, "R2 random ack", acks, 1);
      wait_idle;
      model[ra[k]] = rv[k];
    end
    for (int k = 0; k < 6; k++) read_check(ra[k], 2, 2'(k), "R2 random readback");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule